// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt lines into groups of eight and presents one request line per group to a downstream interrupt controller. A group's request is high whenever at least one of its eight sources is both pending and enabled. Input number n belongs to group n >> 3 and occupies bit n & 7 inside that group.

Software reaches the block through a small synchronous register port. The register space is organised in blocks of four 32-bit words, one block per four consecutive groups, with each group in its own byte lane. One word sets enable bits, one clears them, one shows raw pending bits and one shows pending bits after masking. Two summary words after the last block give one bit per group for the masked state. A build option can stop groups at or above a set limit from ever becoming pending.

Pending state follows the registered input level with no latching. Enable changes reach the group outputs in the cycle after the write. Writes to read-only or unmapped locations change nothing and raise an error pulse.

Top module: `irq_group_combiner`

## Requirements
- R1: Input n sets raw pending bit (n & 7) of group (n >> 3). Group g appears in byte lane (g & 3), at bits 8*(g & 3)+7 down to 8*(g & 3), of the block at byte offset 16*(g >> 2).
- R2: A pending bit follows its input level with no latching. It reaches grp_irq two rising edges after the input changes and is not yet visible after one edge.
- R3: grp_irq[g] is 1 exactly when the enable mask of group g ANDed with its pending bits is nonzero.
- R4: A write to block word 0 (byte offset 16*q) ORs each 1 bit of the data into the masks of the four groups of block q. Bits written as 0 leave the mask as it was.
- R5: A write to block word 1 (offset 16*q + 4) clears every mask bit that is written as 1 and leaves the other mask bits unchanged.
- R6: Block word 2 (offset 16*q + 8) reads the raw pending bits. Block word 3 (offset 16*q + 12) reads the pending bits ANDed with the mask. Both use the lane layout of R1.
- R7: The word at offset 0x100 reads the masked state of groups 0 to 31 with group g in bit g. The word at 0x104 reads groups 32 to 63 with group g in bit g-32.
- R8: Reading word 0 or word 1 of a block returns the last value written there. After reset, the words at 0xC0, 0xC4, 0xD0 and 0xD4 read 0x01010101. All other stored words, all masks, all pending bits and grp_irq reset to zero.
- R9: With the limit enabled (default limit 40), inputs of groups at or above the limit never become pending, and the output for such a group stays low even when its mask is set. Group 39 still works.
- R10: A write to word 2 or 3 of a block, to offset 0x100 or above, or to an address that is not word aligned changes nothing. Such a write drives bus_err high for exactly the cycle after the write edge. A legal write leaves bus_err low. A read at 0x108 or above returns 0.
- R11: bus_rdata holds the data for the address presented one rising edge earlier. A mask write shows on grp_irq right after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| irq_src | input | NUM_GROUPS*8 | Level interrupt sources, bit n in group n>>3 |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| bus_err | output | 1 | One-cycle pulse after an illegal write |
| grp_irq | output | NUM_GROUPS | Masked request line per group |

## Verification
An input change is due on grp_irq after exactly two rising edges. A mask write is due on grp_irq, and bus_err is due, at the first falling edge after the write edge. Read data is due one rising edge after the address is presented. The bench drives every stimulus on a falling edge and then waits the exact number of falling edges each result needs before it samples. One case also samples one edge early to confirm that an input change is not yet visible.

// File: rtl/igc_pkg.sv
package igc_pkg;
  localparam int LANE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int QUAD_GRPS = WORD_W / LANE_W;

  // position of a word inside one four-group register block
  typedef enum logic [1:0] {
    WK_SET = 2'd0,
    WK_CLR = 2'd1,
    WK_RAW = 2'd2,
    WK_MSK = 2'd3
  } word_kind_e;
endpackage

// File: rtl/igc_capture.sv
module igc_capture
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS  = 64,
  parameter bit LIMIT_EN    = 1'b1,
  parameter int GROUP_LIMIT = 40
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GROUPS*LANE_W-1:0]   src_i,
  output logic [NUM_GROUPS*LANE_W-1:0]   pend_o
);
  localparam int NSRC = NUM_GROUPS * LANE_W;

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] accept;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_accept
    localparam bit OK = !LIMIT_EN || (g < GROUP_LIMIT);
    assign accept[g*LANE_W +: LANE_W] = OK ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= src_q & accept;
    end
  end

  AST_PEND_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & ~$past(src_q)) == '0)); // R2
endmodule

// File: rtl/igc_regfile.sv
module igc_regfile
  import igc_pkg::*;
#(
  parameter int          NUM_GROUPS  = 64,
  parameter int          ADDR_W      = 9,
  parameter int          INIT_QUAD_A = 12,
  parameter int          INIT_QUAD_B = 13,
  parameter logic [31:0] INIT_VAL    = 32'h0101_0101
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [WORD_W-1:0]                    wdata,
  output logic [NUM_GROUPS*LANE_W-1:0]         mask_o,
  output logic [(NUM_GROUPS/QUAD_GRPS)*2*WORD_W-1:0] shadow_o,
  output logic                                 err_o
);
  localparam int NQUAD  = NUM_GROUPS / QUAD_GRPS;
  localparam int QIDX_W = (NQUAD > 1) ? $clog2(NQUAD) : 1;
  localparam int SEL_W  = ADDR_W - 4;

  logic [SEL_W-1:0]  qsel;
  logic [QIDX_W-1:0] qidx;
  word_kind_e        kind;
  logic              in_quads;
  logic              aligned;
  logic              do_set;
  logic              do_clr;

  assign qsel     = addr[ADDR_W-1:4];
  assign qidx     = qsel[QIDX_W-1:0];
  assign kind     = word_kind_e'(addr[3:2]);
  assign in_quads = (qsel < SEL_W'(NQUAD));
  assign aligned  = (addr[1:0] == 2'b00);
  assign do_set   = wr_en && in_quads && aligned && (kind == WK_SET);
  assign do_clr   = wr_en && in_quads && aligned && (kind == WK_CLR);

  for (genvar q = 0; q < NQUAD; q++) begin : g_quad
    localparam logic [WORD_W-1:0] RST_V =
      ((q == INIT_QUAD_A) || (q == INIT_QUAD_B)) ? INIT_VAL : '0;
    logic              hit;
    logic [WORD_W-1:0] set_w;
    logic [WORD_W-1:0] clr_w;
    logic [WORD_W-1:0] msk_w;

    assign hit = (qidx == QIDX_W'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        set_w <= RST_V;
        clr_w <= RST_V;
        msk_w <= '0;
      end else begin
        if (do_set && hit) begin
          set_w <= wdata;
          msk_w <= msk_w | wdata;
        end
        if (do_clr && hit) begin
          clr_w <= wdata;
          msk_w <= msk_w & ~wdata;
        end
      end
    end

    assign mask_o[q*WORD_W +: WORD_W]           = msk_w;
    assign shadow_o[(2*q)*WORD_W +: WORD_W]     = set_w;
    assign shadow_o[(2*q+1)*WORD_W +: WORD_W]   = clr_w;
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= wr_en && !(do_set || do_clr);
  end

  AST_SET_ORS_BITS: assert property (@(posedge clk) disable iff (rst)
    do_set |=> ((mask_o[$past(qidx)*WORD_W +: WORD_W] & $past(wdata)) == $past(wdata))); // R4
  AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> ((mask_o[$past(qidx)*WORD_W +: WORD_W] & $past(wdata)) == '0)); // R5
  AST_ERR_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(mask_o)); // R10
endmodule

// File: rtl/igc_readback.sv
module igc_readback
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic [NUM_GROUPS*LANE_W-1:0]               pend_i,
  input  logic [NUM_GROUPS*LANE_W-1:0]               mask_i,
  input  logic [(NUM_GROUPS/QUAD_GRPS)*2*WORD_W-1:0] shadow_i,
  output logic [NUM_GROUPS-1:0]                      act_o,
  output logic [WORD_W-1:0]                          rdata_o
);
  localparam int NQUAD  = NUM_GROUPS / QUAD_GRPS;
  localparam int QIDX_W = (NQUAD > 1) ? $clog2(NQUAD) : 1;
  localparam int SEL_W  = ADDR_W - 4;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int WSUM   = NQUAD * QUAD_GRPS;
  localparam int SUM_W  = 2 * WORD_W;

  logic [SUM_W-1:0]  sum_vec;
  logic [SEL_W-1:0]  qsel;
  logic [QIDX_W-1:0] qidx;
  logic [WIDX_W-1:0] widx;
  word_kind_e        kind;
  logic [WORD_W-1:0] nxt;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_act
    assign act_o[g] = |(pend_i[g*LANE_W +: LANE_W] & mask_i[g*LANE_W +: LANE_W]);
  end

  always_comb begin
    sum_vec = '0;
    sum_vec[NUM_GROUPS-1:0] = act_o;
  end

  assign qsel = addr[ADDR_W-1:4];
  assign qidx = qsel[QIDX_W-1:0];
  assign widx = addr[ADDR_W-1:2];
  assign kind = word_kind_e'(addr[3:2]);

  always_comb begin
    int b;
    b   = int'(qidx);
    nxt = '0;
    if (addr[1:0] == 2'b00) begin
      if (qsel < SEL_W'(NQUAD)) begin
        case (kind)
          WK_SET:  nxt = shadow_i[(2*b)*WORD_W +: WORD_W];
          WK_CLR:  nxt = shadow_i[(2*b+1)*WORD_W +: WORD_W];
          WK_RAW:  nxt = pend_i[b*WORD_W +: WORD_W];
          default: nxt = pend_i[b*WORD_W +: WORD_W] & mask_i[b*WORD_W +: WORD_W];
        endcase
      end else if (widx == WIDX_W'(WSUM)) begin
        nxt = sum_vec[WORD_W-1:0];
      end else if (widx == WIDX_W'(WSUM + 1)) begin
        nxt = sum_vec[SUM_W-1:WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= nxt;
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import igc_pkg::*;
#(
  parameter int          NUM_GROUPS  = 64,
  parameter int          ADDR_W      = 9,
  parameter bit          LIMIT_EN    = 1'b1,
  parameter int          GROUP_LIMIT = 40,
  parameter int          INIT_QUAD_A = 12,
  parameter int          INIT_QUAD_B = 13,
  parameter logic [31:0] INIT_VAL    = 32'h0101_0101
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_GROUPS*8-1:0]       irq_src,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          bus_err,
  output logic [NUM_GROUPS-1:0]         grp_irq
);
  localparam int NSRC  = NUM_GROUPS * LANE_W;
  localparam int NQUAD = NUM_GROUPS / QUAD_GRPS;

  logic [NSRC-1:0]             pend;
  logic [NSRC-1:0]             mask;
  logic [NQUAD*2*WORD_W-1:0]   shadow;
  logic [NUM_GROUPS-1:0]       pend_any;

  igc_capture #(
    .NUM_GROUPS (NUM_GROUPS),
    .LIMIT_EN   (LIMIT_EN),
    .GROUP_LIMIT(GROUP_LIMIT)
  ) u_capture (
    .clk   (clk),
    .rst   (rst),
    .src_i (irq_src),
    .pend_o(pend)
  );

  igc_regfile #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .INIT_QUAD_A(INIT_QUAD_A),
    .INIT_QUAD_B(INIT_QUAD_B),
    .INIT_VAL   (INIT_VAL)
  ) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .mask_o  (mask),
    .shadow_o(shadow),
    .err_o   (bus_err)
  );

  igc_readback #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W)
  ) u_readback (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .pend_i  (pend),
    .mask_i  (mask),
    .shadow_i(shadow),
    .act_o   (grp_irq),
    .rdata_o (bus_rdata)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
    assign pend_any[g] = |pend[g*LANE_W +: LANE_W];
  end

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ((grp_irq & ~pend_any) == '0)); // R3
  AST_LIMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!LIMIT_EN || ((grp_irq >> GROUP_LIMIT) == '0))); // R9
endmodule

// File: tb/irq_group_combiner_bench.sv
`timescale 1ns/1ps
module irq_group_combiner_bench;
  localparam int NG = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG*8-1:0] irq_src = '0;
  logic [8:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NG-1:0] grp_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_group_combiner u_irq_group_combiner (
    .clk      (clk),
    .rst      (rst),
    .irq_src  (irq_src),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .grp_irq  (grp_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    chk(tag, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic src(input int n, input logic v);
    @(negedge clk);
    irq_src[n] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 grp_irq after reset", grp_irq, '0);
    chk("R8 bus_err after reset", {63'h0, bus_err}, 64'h0);
    rd_chk("R8 reset word 0xC0", 9'h0C0, 32'h0101_0101);
    rd_chk("R8 reset word 0xC4", 9'h0C4, 32'h0101_0101);
    rd_chk("R8 reset word 0xD0", 9'h0D0, 32'h0101_0101);
    rd_chk("R8 reset word 0xD4", 9'h0D4, 32'h0101_0101);
    rd_chk("R8 reset word 0x00", 9'h000, 32'h0);
    rd_chk("R7 reset summary", 9'h100, 32'h0);
  endtask

  task automatic t_map;
    src(77, 1'b1);
    src(3, 1'b1);
    rd_chk("R1 raw group 9 bit 5", 9'h028, 32'h0000_2000);
    rd_chk("R1 raw group 0 bit 3", 9'h008, 32'h0000_0008);
    chk("R3 no mask no irq", grp_irq, '0);
  endtask

  task automatic t_enable;
    wr(9'h020, 32'h0000_2000);
    chk("R11 R4 irq right after set write", {63'h0, grp_irq[9]}, 64'h1);
    rd_chk("R6 masked word", 9'h02C, 32'h0000_2000);
    rd_chk("R7 summary low", 9'h100, 32'h0000_0200);
    rd_chk("R7 summary high", 9'h104, 32'h0);
    rd_chk("R8 set word readback", 9'h020, 32'h0000_2000);
  endtask

  task automatic t_level;
    src(77, 1'b0);
    chk("R2 irq drops with input", {63'h0, grp_irq[9]}, 64'h0);
    rd_chk("R2 raw clears", 9'h028, 32'h0);
    @(negedge clk);
    irq_src[77] = 1'b1;
    @(negedge clk);
    chk("R2 not visible after one edge", {63'h0, grp_irq[9]}, 64'h0);
    @(negedge clk);
    chk("R2 visible after two edges", {63'h0, grp_irq[9]}, 64'h1);
  endtask

  task automatic t_disable;
    wr(9'h024, 32'h0000_2000);
    chk("R5 irq off after clear", {63'h0, grp_irq[9]}, 64'h0);
    rd_chk("R5 masked word zero", 9'h02C, 32'h0);
    rd_chk("R8 clr word readback", 9'h024, 32'h0000_2000);
    rd_chk("R7 summary cleared", 9'h100, 32'h0);
    rd_chk("R6 raw still set", 9'h028, 32'h0000_2000);
  endtask

  task automatic t_or;
    src(0, 1'b1);
    src(1, 1'b1);
    wr(9'h000, 32'h1);
    wr(9'h000, 32'h2);
    rd_chk("R4 set bits accumulate", 9'h00C, 32'h3);
    rd_chk("R8 last written value", 9'h000, 32'h2);
    chk("R3 group 0 on", {63'h0, grp_irq[0]}, 64'h1);
    wr(9'h004, 32'h1);
    rd_chk("R5 only written bit cleared", 9'h00C, 32'h2);
  endtask

  task automatic t_high;
    src(264, 1'b1);
    wr(9'h080, 32'h0000_0100);
    chk("R3 group 33 on", {63'h0, grp_irq[33]}, 64'h1);
    rd_chk("R7 summary high group 33", 9'h104, 32'h2);
    rd_chk("R7 summary low group 0", 9'h100, 32'h1);
  endtask

  task automatic t_limit;
    src(319, 1'b1);
    wr(9'h090, 32'h8000_0000);
    chk("R9 group 39 accepted", {63'h0, grp_irq[39]}, 64'h1);
    rd_chk("R9 raw group 39", 9'h098, 32'h8000_0000);
    src(360, 1'b1);
    wr(9'h0B0, 32'h0000_0100);
    chk("R9 group 45 ignored", {63'h0, grp_irq[45]}, 64'h0);
    rd_chk("R9 raw group 45 zero", 9'h0B8, 32'h0);
    rd_chk("R9 R7 summary high", 9'h104, 32'h82);
  endtask

  task automatic t_illegal;
    logic [NG-1:0] snap;
    snap = grp_irq;
    wr(9'h028, 32'hFFFF_FFFF);
    chk("R10 err on raw word write", {63'h0, bus_err}, 64'h1);
    @(negedge clk);
    chk("R10 err one cycle", {63'h0, bus_err}, 64'h0);
    rd_chk("R10 masked word unchanged", 9'h02C, 32'h0);
    wr(9'h100, 32'hFFFF_FFFF);
    chk("R10 err on summary write", {63'h0, bus_err}, 64'h1);
    wr(9'h022, 32'h0000_2000);
    chk("R10 err on misaligned write", {63'h0, bus_err}, 64'h1);
    chk("R10 outputs unchanged", grp_irq, snap);
    rd_chk("R10 set word unchanged", 9'h020, 32'h0000_2000);
    wr(9'h044, 32'h0);
    chk("R10 legal write no err", {63'h0, bus_err}, 64'h0);
    rd_chk("R10 read past window", 9'h108, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_enable();
    t_level();
    t_disable();
    t_or();
    t_high();
    t_limit();
    t_illegal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule